// File: doc/BRIEF.md
# Quasi-Bidirectional I2C Port Expander

This block is an I2C target that gives a host 8 or 16 general-purpose pins through one output latch and one input snapshot. There is no register pointer. A write transfer carries data bytes straight into the latch. A read transfer returns the pin levels. Each pin has only two states. A latch bit of 0 makes the pin pull low. A latch bit of 1 releases the pin to a weak high, so an outside source can drive it and the pin works as an input. Because the latch resets to all ones, every pin starts out as an input.

The block samples SCL and SDA in a system clock that runs at least eight times the bus rate. It drives SDA low through an open-drain enable. An active interrupt output, also open drain, tells the host that some input has moved away from the value it last read. The pad circuits sit outside the block. The testbench models them as wired-AND nets.

Top module: `qbx_expander`

## Requirements
- R1: After reset, the latch holds all ones, so `pin_drive_low` is all zeros. `irq_pull` and `sda_oe` are both 0.
- R2: The target acknowledges the 7-bit address formed by the base (0x20 by default, or 0x38 when `ALT_BASE`=1) with its three low bits replaced by `addr_strap`. The address byte carries R/W in bit 0, where 1 means read. For any other address the target leaves SDA released for the acknowledge slot and ignores the bus until the next START.
- R3: Each write data byte is loaded into its half of the latch on the acknowledge that follows the byte. A latch bit of 0 sets the matching `pin_drive_low` bit to 1.
- R4: With 16 pins, the first data byte of a write goes to pins 0-7 and the second to pins 8-15. Further bytes keep alternating between the two halves.
- R5: A read returns the pin levels captured on the acknowledge of the read address, not the latch contents. Bytes come out with pins 0-7 first. While the host keeps acknowledging, the bytes alternate between the two halves. A host not-acknowledge ends the read.
- R6: `irq_pull` is 1 whenever the synchronized pin levels differ from the reference. The reference is all ones at reset and is reloaded on every read-address acknowledge. A reload clears the interrupt. The interrupt also clears when the pins return to the reference.
- R7: A STOP or a repeated START inside a data byte ends the transfer and leaves the latch unchanged.
- R8: The target raises `sda_oe` only while SCL is low, and it releases SDA after a STOP.
- R9: The latch changes only on a write acknowledge. A read transfer leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_strap | input | 3 | Low three bits of the target address |
| pin_i | input | NPINS | Levels seen on the port pins |
| pin_drive_low | output | NPINS | 1 pulls the pin low; 0 leaves it weakly high |
| irq_pull | output | 1 | 1 pulls the open-drain interrupt line low |

## Verification
The hardest cases to reach are the ones where the bus breaks off inside a byte. The bench has to land a STOP or a repeated START after only a few data bits, once the address has been accepted. It then proves that the latch was untouched, either by looking at the pin drivers or by reading the pins back in a fresh read. The bench's controller model builds these cases by emitting a partial byte and then the bus condition, with SCL low.

The interrupt needs an external pin level that differs from what the latch implies. The bench reaches it by pulling an external pin net low while its latch bit is 1. The sequence is: change the pin, restore it, then run a read, which reloads the reference.

// File: rtl/qbx_pkg.sv
package qbx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } qbx_state_e;

  localparam logic [6:0] BASE_STD = 7'h20;
  localparam logic [6:0] BASE_ALT = 7'h38;
endpackage

// File: rtl/qbx_bus_sync.sv
module qbx_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_p  <= scl_ff[1];
      sda_p  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/qbx_target_fsm.sv
module qbx_target_fsm
  import qbx_pkg::*;
#(
  parameter int NPINS    = 16,
  parameter bit ALT_BASE = 1'b0,
  parameter int NBYTES   = NPINS / 8,
  parameter int IDXW     = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            bus_start,
  input  logic            bus_stop,
  input  logic            sda_s,
  input  logic [2:0]      addr_strap,
  input  logic [7:0]      rd_byte,
  output logic [IDXW-1:0] rd_sel,
  output logic            sda_oe,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_sel,
  output logic [7:0]      wr_byte,
  output logic            sample_en
);
  localparam logic [6:0] BASE = ALT_BASE ? BASE_ALT : BASE_STD;

  qbx_state_e      state_q, state_n;
  logic [3:0]      cnt_q, cnt_n;
  logic [7:0]      sh_q, sh_n;
  logic [IDXW-1:0] idx_q, idx_n, idx_inc;
  logic            rw_q, rw_n;
  logic            mack_q, mack_n;
  logic            addr_hit, no_cond, byte_end;

  assign addr_hit = (sh_q[7:1] == {BASE[6:3], addr_strap});
  assign idx_inc  = (idx_q == IDXW'(NBYTES - 1)) ? '0 : idx_q + IDXW'(1);
  assign no_cond  = ~bus_start & ~bus_stop;
  assign byte_end = scl_fall & (cnt_q == 4'd8) & no_cond;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    idx_n   = idx_q;
    rw_n    = rw_q;
    mack_n  = mack_q;
    if (bus_start) begin
      state_n = ST_ADDR;
      cnt_n   = 4'd0;
    end else if (bus_stop) begin
      state_n = ST_IDLE;
    end else begin
      case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                state_n = ST_ADDR_ACK;
                rw_n    = sh_q[0];
                idx_n   = '0;
              end else begin
                state_n = ST_IDLE;
              end
            end else begin
              state_n = ST_WR_ACK;
              idx_n   = idx_inc;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_n = 4'd0;
            if (rw_q) begin
              state_n = ST_RD;
              sh_n    = rd_byte;
              idx_n   = idx_inc;
            end else begin
              state_n = ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            state_n = ST_WR;
            cnt_n   = 4'd0;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              state_n = ST_RD_ACK;
            end else begin
              sh_n  = {sh_q[6:0], 1'b0};
              cnt_n = cnt_q + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_n = ST_RD;
              cnt_n   = 4'd0;
              sh_n    = rd_byte;
              idx_n   = idx_inc;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 4'd0;
      sh_q    <= 8'h00;
      idx_q   <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      idx_q   <= idx_n;
      rw_q    <= rw_n;
      mack_q  <= mack_n;
    end
  end

  assign sda_oe    = (state_q == ST_ADDR_ACK) | (state_q == ST_WR_ACK) |
                     ((state_q == ST_RD) & ~sh_q[7]);
  assign wr_en     = (state_q == ST_WR) & byte_end;
  assign wr_sel    = idx_q;
  assign wr_byte   = sh_q;
  assign rd_sel    = idx_q;
  assign sample_en = (state_q == ST_ADDR) & byte_end & addr_hit & sh_q[0];
endmodule

// File: rtl/qbx_port_bank.sv
module qbx_port_bank #(
  parameter int NPINS  = 16,
  parameter int NBYTES = NPINS / 8,
  parameter int IDXW   = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_sel,
  input  logic [7:0]       wr_byte,
  input  logic             sample_en,
  input  logic [IDXW-1:0]  rd_sel,
  output logic [7:0]       rd_byte,
  output logic [NPINS-1:0] pin_drive_low,
  output logic             irq_pull
);
  logic [NPINS-1:0] latch_q, latch_n;
  logic [NPINS-1:0] pin_m, pin_s;
  logic [NPINS-1:0] snap_q, snap_n;
  logic             irq_q, irq_n;

  always_comb begin
    latch_n = latch_q;
    for (int b = 0; b < NBYTES; b++) begin
      if (wr_en && wr_sel == IDXW'(b)) latch_n[b*8 +: 8] = wr_byte;
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    for (int b = 0; b < NBYTES; b++) begin
      if (rd_sel == IDXW'(b)) rd_byte = snap_q[b*8 +: 8];
    end
  end

  assign snap_n = sample_en ? pin_s : snap_q;
  assign irq_n  = sample_en ? 1'b0 : (pin_s != snap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      pin_m   <= '1;
      pin_s   <= '1;
      snap_q  <= '1;
      irq_q   <= 1'b0;
    end else begin
      latch_q <= latch_n;
      pin_m   <= pin_i;
      pin_s   <= pin_m;
      snap_q  <= snap_n;
      irq_q   <= irq_n;
    end
  end

  assign pin_drive_low = ~latch_q;
  assign irq_pull      = irq_q;
endmodule

// File: rtl/qbx_expander.sv
module qbx_expander #(
  parameter int NPINS    = 16,
  parameter bit ALT_BASE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [2:0]       addr_strap,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_drive_low,
  output logic             irq_pull
);
  localparam int NBYTES = NPINS / 8;
  localparam int IDXW   = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [1:0]      rst_pipe;
  logic            rst_int_n;
  logic            scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic            wr_en, sample_en;
  logic [IDXW-1:0] wr_sel, rd_sel;
  logic [7:0]      wr_byte, rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  qbx_bus_sync u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  qbx_target_fsm #(.NPINS(NPINS), .ALT_BASE(ALT_BASE), .NBYTES(NBYTES), .IDXW(IDXW)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_s(sda_s),
    .addr_strap(addr_strap), .rd_byte(rd_byte), .rd_sel(rd_sel),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte),
    .sample_en(sample_en)
  );

  qbx_port_bank #(.NPINS(NPINS), .NBYTES(NBYTES), .IDXW(IDXW)) u_port (
    .clk(clk), .rst_n(rst_int_n), .pin_i(pin_i), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_byte(wr_byte), .sample_en(sample_en),
    .rd_sel(rd_sel), .rd_byte(rd_byte), .pin_drive_low(pin_drive_low),
    .irq_pull(irq_pull)
  );
endmodule

// File: rtl/qbx_expander_chk.sv
module qbx_expander_chk #(
  parameter int NPINS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input logic             bus_stop,
  input logic             wr_en,
  input logic             sample_en,
  input logic [NPINS-1:0] pin_drive_low,
  input logic             irq_pull
);
  AST_SDA_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> !$rose(sda_oe)); // R8
  AST_SDA_FREE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_oe); // R8
  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_drive_low)); // R9
  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R3
  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> !irq_pull); // R6
  AST_NO_LOAD_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> !wr_en); // R9
endmodule

bind qbx_expander qbx_expander_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .bus_stop(bus_stop), .wr_en(wr_en), .sample_en(sample_en),
  .pin_drive_low(pin_drive_low), .irq_pull(irq_pull)
);

// File: tb/qbx_expander_tb.sv
module qbx_expander_tb;
  localparam int NPINS = 16;
  localparam int Q     = 10;

  logic             clk;
  logic             rst_n;
  logic             scl_m, sda_m;
  logic             sda_oe, irq_pull;
  logic [2:0]       addr_strap;
  logic [NPINS-1:0] ext_pin, pin_line, pin_drive_low;
  logic             sda_line;
  int               checks, failures;

  assign sda_line = sda_m & ~sda_oe;
  assign pin_line = ext_pin & ~pin_drive_low;

  qbx_expander #(.NPINS(NPINS), .ALT_BASE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_strap(addr_strap), .pin_i(pin_line),
    .pin_drive_low(pin_drive_low), .irq_pull(irq_pull)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    acked = ~a;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic ack_it);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(~ack_it);
  endtask

  task automatic t_reset();
    check("R1 drive_low", 32'(pin_drive_low), 32'h0);
    check("R1 irq", 32'(irq_pull), 32'h0);
    check("R1 sda_oe", 32'(sda_oe), 32'h0);
  endtask

  task automatic t_address();
    logic a;
    bus_start();
    put_byte(8'h48, a);
    check("R2 wrong address nack", 32'(a), 32'h0);
    put_byte(8'h00, a);
    check("R2 ignored until start", 32'(a), 32'h0);
    bus_stop();
    check("R2 latch untouched", 32'(pin_drive_low), 32'h0);
    bus_start();
    put_byte(8'h4A, a);
    check("R2 own address ack", 32'(a), 32'h1);
    bus_stop();
    check("R8 sda released after stop", 32'(sda_oe), 32'h0);
  endtask

  task automatic t_write_two();
    logic a;
    bus_start();
    put_byte(8'h4A, a);
    put_byte(8'hA5, a);
    check("R3 low byte ack", 32'(a), 32'h1);
    check("R3 low byte drivers", 32'(pin_drive_low), 32'h005A);
    put_byte(8'h3C, a);
    check("R4 high byte drivers", 32'(pin_drive_low), 32'hC35A);
    bus_stop();
  endtask

  task automatic t_read_pins();
    logic       a;
    logic [7:0] d0, d1, d2;
    ext_pin[0] = 1'b0;
    tick(Q);
    bus_start();
    put_byte(8'h4B, a);
    check("R5 read address ack", 32'(a), 32'h1);
    get_byte(d0, 1'b1);
    get_byte(d1, 1'b1);
    get_byte(d2, 1'b0);
    bus_stop();
    check("R5 low byte shows pin not latch", 32'(d0), 32'hA4);
    check("R5 high byte", 32'(d1), 32'h3C);
    check("R5 wrap to low byte", 32'(d2), 32'hA4);
    check("R9 read leaves latch", 32'(pin_drive_low), 32'hC35A);
  endtask

  task automatic t_irq();
    logic       a;
    logic [7:0] d;
    check("R6 quiet after read", 32'(irq_pull), 32'h0);
    ext_pin[0] = 1'b1; tick(Q);
    check("R6 asserts on change", 32'(irq_pull), 32'h1);
    ext_pin[0] = 1'b0; tick(Q);
    check("R6 clears on return", 32'(irq_pull), 32'h0);
    ext_pin[0] = 1'b1; tick(Q);
    check("R6 asserts again", 32'(irq_pull), 32'h1);
    bus_start();
    put_byte(8'h4B, a);
    tick(2);
    check("R6 cleared by read", 32'(irq_pull), 32'h0);
    get_byte(d, 1'b0);
    bus_stop();
    check("R6 read value", 32'(d), 32'hA5);
  endtask

  task automatic t_wrap_write();
    logic a;
    bus_start();
    put_byte(8'h4A, a);
    put_byte(8'hFF, a);
    put_byte(8'hFF, a);
    put_byte(8'h0F, a);
    bus_stop();
    check("R4 third byte wraps to low", 32'(pin_drive_low), 32'h00F0);
  endtask

  task automatic t_abort();
    logic       a;
    logic [7:0] d;
    bus_start();
    put_byte(8'h4A, a);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_stop();
    check("R7 stop mid-byte", 32'(pin_drive_low), 32'h00F0);
    bus_start();
    put_byte(8'h4A, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start();
    put_byte(8'h4B, a);
    check("R7 restart accepted", 32'(a), 32'h1);
    get_byte(d, 1'b0);
    bus_stop();
    check("R7 restart mid-byte latch", 32'(pin_drive_low), 32'h00F0);
    check("R7 pins read back", 32'(d), 32'h0F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    addr_strap = 3'b101; ext_pin = '1;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_address();
    t_write_two();
    t_read_pins();
    t_irq();
    t_wrap_write();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule